// File: doc/BRIEF.md
# Control Register Write Validator

This block holds the five architectural control registers (CR0, CR2, CR3, CR4 and CR8) and screens every write made to them. A request carries a 4-bit register index and a 64-bit value. The block decides whether the write is legal before it changes any state. That decision uses the new value, the CR4 contents already held, the extended-feature long-mode enable bit and a flag that says the core is running in long mode. A legal write is stored. An illegal one is dropped, and the block reports either an invalid-opcode fault or a general-protection fault with error code 0.

The block does not produce side effects. Paging, cache control and TLB maintenance are left to the logic that reads the register outputs.

Top module: `ctrl_reg_guard`

## Requirements
- R1: A write request to index 1, to indices 5, 6 or 7, or to any index from 9 to 15 is refused with fault code 01 (invalid opcode).
- R2: A CR0 write (index 0) with any of bits 63:32 set is refused with fault code 10 (general protection).
- R3: A CR0 write with bit 31 (paging) set and bit 0 (protection enable) clear is refused with fault code 10.
- R4: A CR0 write with bit 29 (not-write-through) set and bit 30 (cache disable) clear is refused with fault code 10.
- R5: A CR0 write with bit 31 set while `efer_lme` is high and the CR4 value held at that moment has bit 5 (PAE) clear is refused with fault code 10.
- R6: A CR4 write (index 4) is refused with fault code 10 in either of two cases: any of bits 63:11 is set, or bit 5 is clear while `long_mode` is high.
- R7: A CR8 write (index 8) with any of bits 63:4 set is refused with fault code 10.
- R8: A write to CR2 (index 2) or CR3 (index 3) is always accepted, whatever its value.
- R9: A legal write appears on its register output from the clock edge that samples the request. A refused write leaves all five registers unchanged.
- R10: After each sampled request, `fault_code` shows the outcome for exactly one cycle (00 none, 01 invalid opcode, 10 general protection, never 11). `fault_pulse` is high exactly when `fault_code` is non-zero. In cycles with no request, both outputs read zero.
- R11: While reset is active, all five registers read zero (so CR0 has protection enable clear) and no fault is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request strobe |
| wr_idx | input | 4 | Control register index |
| wr_data | input | 64 | Value to be written |
| efer_lme | input | 1 | Long-mode enable from the extended feature register |
| long_mode | input | 1 | Core currently executing in long mode |
| fault_pulse | output | 1 | One-cycle pulse for a refused write |
| fault_code | output | 2 | Outcome of the last request: 00 none, 01 invalid opcode, 10 general protection |
| cr0_q | output | 64 | CR0 contents |
| cr2_q | output | 64 | CR2 contents |
| cr3_q | output | 64 | CR3 contents |
| cr4_q | output | 64 | CR4 contents |
| cr8_q | output | 64 | CR8 contents |

## Verification
The hardest cases to reach are the two rules that depend on state held from earlier writes and on the mode inputs, not on the new value alone.

- Enabling paging with long mode enabled must fault only when the PAE bit is clear in the CR4 value already held. Reaching both outcomes needs a CR4 write first, then a CR0 write with `efer_lme` set.
- Clearing PAE must fault only while `long_mode` is high.

Directed sequences set up each ordering explicitly. After that, random writes with shaped values and random mode bits keep the held CR4 changing, so that CR0 paging writes meet both PAE states.

// File: rtl/ctrl_reg_guard.sv
module ctrl_reg_guard #(
  parameter int XLEN      = 64,
  parameter int IDXW      = 4,
  parameter int CR4_TOP_OK = 11,
  parameter int CR8_TOP_OK = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            efer_lme,
  input  logic            long_mode,
  output logic            fault_pulse,
  output logic [1:0]      fault_code,
  output logic [XLEN-1:0] cr0_q,
  output logic [XLEN-1:0] cr2_q,
  output logic [XLEN-1:0] cr3_q,
  output logic [XLEN-1:0] cr4_q,
  output logic [XLEN-1:0] cr8_q
);
  localparam int B_PE  = 0;
  localparam int B_NW  = 29;
  localparam int B_CD  = 30;
  localparam int B_PG  = 31;
  localparam int B_PAE = 5;
  localparam logic [1:0] FC_NONE = 2'b00;
  localparam logic [1:0] FC_UD   = 2'b01;
  localparam logic [1:0] FC_GP   = 2'b10;

  logic [1:0] verdict;
  logic       commit;
  logic [1:0] code_q;

  wire cr0_hi_bad  = |wr_data[XLEN-1:32];
  wire cr0_pg_nope = wr_data[B_PG] & ~wr_data[B_PE];
  wire cr0_nw_nocd = wr_data[B_NW] & ~wr_data[B_CD];
  wire cr0_lm_nopae = wr_data[B_PG] & efer_lme & ~cr4_q[B_PAE];
  wire cr4_hi_bad  = |wr_data[XLEN-1:CR4_TOP_OK];
  wire cr4_pae_off = long_mode & ~wr_data[B_PAE];
  wire cr8_hi_bad  = |wr_data[XLEN-1:CR8_TOP_OK];

  always_comb begin
    case (wr_idx)
      IDXW'(0): verdict = (cr0_hi_bad | cr0_pg_nope | cr0_nw_nocd | cr0_lm_nopae)
                          ? FC_GP : FC_NONE;
      IDXW'(2), IDXW'(3): verdict = FC_NONE;
      IDXW'(4): verdict = (cr4_hi_bad | cr4_pae_off) ? FC_GP : FC_NONE;
      IDXW'(8): verdict = cr8_hi_bad ? FC_GP : FC_NONE;
      default:  verdict = FC_UD;
    endcase
  end

  assign commit = wr_valid && (verdict == FC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0_q  <= '0;
      cr2_q  <= '0;
      cr3_q  <= '0;
      cr4_q  <= '0;
      cr8_q  <= '0;
      code_q <= FC_NONE;
    end else begin
      code_q <= wr_valid ? verdict : FC_NONE;
      if (commit) begin
        case (wr_idx)
          IDXW'(0): cr0_q <= wr_data;
          IDXW'(2): cr2_q <= wr_data;
          IDXW'(3): cr3_q <= wr_data;
          IDXW'(4): cr4_q <= wr_data;
          IDXW'(8): cr8_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign fault_code  = code_q;
  assign fault_pulse = (code_q != FC_NONE);

  p_bad_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_idx == IDXW'(1) || (wr_idx > IDXW'(4) && wr_idx < IDXW'(8))
      || wr_idx > IDXW'(8))) |=> (fault_code == FC_UD));

  p_cr0_upper_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_q[XLEN-1:32] == '0);

  p_cr0_pg_needs_pe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cr0_q[B_PG] && !cr0_q[B_PE]));

  p_cr0_nw_needs_cd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cr0_q[B_NW] && !cr0_q[B_CD]));

  p_cr4_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cr4_q[XLEN-1:CR4_TOP_OK] == '0);

  p_cr8_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cr8_q[XLEN-1:CR8_TOP_OK] == '0);

  p_cr2_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_idx == IDXW'(2)) |=> (cr2_q == $past(wr_data) && fault_code == FC_NONE));

  p_fault_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> ($stable(cr0_q) && $stable(cr2_q) && $stable(cr3_q)
                     && $stable(cr4_q) && $stable(cr8_q)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (fault_code == FC_NONE && !fault_pulse));

  p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code != 2'b11);
endmodule

// File: tb/test_ctrl_reg_guard.sv
`timescale 1ns/1ps
module test_ctrl_reg_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [3:0]  wr_idx;
  logic [63:0] wr_data;
  logic        efer_lme;
  logic        long_mode;
  logic        fault_pulse;
  logic [1:0]  fault_code;
  logic [63:0] cr0_q, cr2_q, cr3_q, cr4_q, cr8_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [63:0] m0, m2, m3, m4, m8;

  always #2.5 clk = ~clk;

  ctrl_reg_guard i_ctrl_reg_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .efer_lme(efer_lme), .long_mode(long_mode),
    .fault_pulse(fault_pulse), .fault_code(fault_code),
    .cr0_q(cr0_q), .cr2_q(cr2_q), .cr3_q(cr3_q), .cr4_q(cr4_q), .cr8_q(cr8_q)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(logic [3:0] idx, logic [63:0] d,
                                          logic [63:0] old4, logic lme, logic lm);
    case (idx)
      4'd0: begin
        if (d[63:32] != 0) return 2'b10;
        if (d[31] && !d[0]) return 2'b10;
        if (d[29] && !d[30]) return 2'b10;
        if (d[31] && lme && !old4[5]) return 2'b10;
        return 2'b00;
      end
      4'd2, 4'd3: return 2'b00;
      4'd4: return (d[63:11] != 0 || (lm && !d[5])) ? 2'b10 : 2'b00;
      4'd8: return (d[63:4] != 0) ? 2'b10 : 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  function automatic string rule_tag(logic [3:0] idx, logic [63:0] d,
                                     logic [63:0] old4, logic lme);
    case (idx)
      4'd0: begin
        if (d[63:32] != 0) return "R2";
        if (d[31] && !d[0]) return "R3";
        if (d[29] && !d[30]) return "R4";
        if (d[31] && lme && !old4[5]) return "R5";
        return "R9";
      end
      4'd2, 4'd3: return "R8";
      4'd4: return "R6";
      4'd8: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check_regs(string tag);
    chk({tag, " cr0"}, cr0_q, m0);
    chk({tag, " cr2"}, cr2_q, m2);
    chk({tag, " cr3"}, cr3_q, m3);
    chk({tag, " cr4"}, cr4_q, m4);
    chk({tag, " cr8"}, cr8_q, m8);
  endtask

  task automatic do_write(logic [3:0] idx, logic [63:0] d, bit idle_after);
    logic [1:0] ec;
    string tag;
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = idx; wr_data = d;
    ec  = exp_code(idx, d, m4, efer_lme, long_mode);
    tag = rule_tag(idx, d, m4, efer_lme);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(tag, {62'd0, fault_code}, {62'd0, ec});
    chk("R10 pulse", {63'd0, fault_pulse}, {63'd0, (ec != 2'b00)});
    if (ec == 2'b00) begin
      case (idx)
        4'd0: m0 = d;
        4'd2: m2 = d;
        4'd3: m3 = d;
        4'd4: m4 = d;
        4'd8: m8 = d;
        default: ;
      endcase
    end
    check_regs("R9");
    if (idle_after) begin
      @(negedge clk);
      chk("R10 idle", {62'd0, fault_code}, 64'd0);
      chk("R10 idle pulse", {63'd0, fault_pulse}, 64'd0);
    end
  endtask

  function automatic logic [63:0] shape(int sel);
    logic [31:0] lo;
    logic [31:0] hi;
    lo = $urandom;
    hi = ($urandom % 6 == 0) ? $urandom : 32'd0;
    case (sel)
      0: return {hi, lo};
      1: return {hi, lo & 32'hE000_0021};
      2: return {32'd0, lo & 32'h0000_07FF};
      default: return {32'd0, lo & 32'h0000_001F};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    rst_n = 1'b0; wr_valid = 1'b0; wr_idx = '0; wr_data = '0;
    efer_lme = 1'b0; long_mode = 1'b0;
    m0 = '0; m2 = '0; m3 = '0; m4 = '0; m8 = '0;
    repeat (3) @(negedge clk);
    check_regs("R11");
    chk("R11 code", {62'd0, fault_code}, 64'd0);
    chk("R11 pulse", {63'd0, fault_pulse}, 64'd0);
    rst_n = 1'b1;

    do_write(4'd4, 64'h20, 1);
    efer_lme = 1'b1;
    do_write(4'd0, 64'h8000_0001, 1);
    long_mode = 1'b1;
    do_write(4'd4, 64'h0, 1);
    do_write(4'd4, 64'h620, 1);
    long_mode = 1'b0;
    do_write(4'd4, 64'h0, 1);
    do_write(4'd0, 64'h8000_0001, 1);
    efer_lme = 1'b0;
    do_write(4'd0, 64'h8000_0001, 1);
    do_write(4'd0, 64'h2000_0001, 1);
    do_write(4'd0, 64'h6000_0001, 1);
    do_write(4'd0, 64'h8000_0000, 1);
    do_write(4'd0, 64'h1_0000_0001, 1);
    do_write(4'd4, 64'h800, 1);
    do_write(4'd4, 64'h7FF, 1);
    do_write(4'd8, 64'hF, 1);
    do_write(4'd8, 64'h10, 1);
    do_write(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    do_write(4'd3, 64'hDEAD_BEEF_1234_5678, 1);
    foreach (m0[i]) if (i < 16 && !(i inside {0, 2, 3, 4, 8}))
      do_write(4'(i), 64'h1, 1);
    do_write(4'd3, 64'h0, 0);
    do_write(4'd1, 64'h5, 0);

    for (int k = 0; k < 3000; k++) begin
      logic [3:0] idx;
      int r;
      r = $urandom % 10;
      idx = (r < 3) ? 4'd0 : (r < 5) ? 4'd4 : (r < 6) ? 4'd8 :
            (r < 7) ? 4'(2 + $urandom % 2) : 4'($urandom);
      efer_lme  = ($urandom % 2) == 1;
      long_mode = ($urandom % 3) == 0;
      do_write(idx, shape(int'($urandom % 4)), ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule